// File: doc/BRIEF.md
# Fixed-Frequency Push-Pull PWM Controller with Deadtime

This block is a digital pulse-width modulator for switch-mode power control. A free-running ramp counter takes the place of an analogue timing capacitor. In each ramp cycle, drive is allowed only while the ramp value is above the larger of two digitised control values. One control value is the loop feedback and the other is a deadtime setting. Whichever of the two asks for the shorter on-time therefore governs the pulse. A fixed blanking window at the start of every ramp cycle enforces a minimum off-time, even when both control values are zero.

There are two output modes. In push-pull mode, a steering flip-flop hands successive pulses to the two drive outputs in turn, so each output runs at half the ramp rate. In single-ended mode the steering is held, both outputs carry the same pulse, and they run at the ramp rate. The ramp period, both control values and the mode are taken in only when the ramp wraps, so a pulse is never cut short or stretched partway through a cycle.

An undervoltage lockout input keeps both outputs inactive. After supply-good returns, release waits until the input has stayed good for a set number of clock cycles. A drop takes effect immediately.

Top module: `pwm_dt_ctrl`

## Requirements
- R1: The ramp counts 0, 1, … P−1 and then wraps to 0. The period P is taken from `period_i` at reset and at each wrap, and any value below 2 is used as 2. `cyc_start_o` is high exactly in the clock cycles where the ramp is at 0.
- R2: A drive output can be high only while the ramp value is strictly greater than max(fb, dt). Outside the blanking window, each active ramp cycle therefore gives P−1−max(fb, dt) high cycles, and none when max(fb, dt) ≥ P−1.
- R3: For ramp values below ceil(P·4/100), both outputs are low, whatever the control values are.
- R4: With `push_pull_i`=1, consecutive ramp cycles alternate between `drv1_o` and `drv2_o`. In the first ramp cycle after reset, `drv1_o` carries the pulse.
- R5: With `push_pull_i`=0, `drv1_o` and `drv2_o` are identical in every cycle.
- R6: In push-pull mode, `drv1_o` and `drv2_o` are never high in the same cycle.
- R7: After `supply_ok_i` is sampled low, both outputs are low from the next cycle. They may drive again only after `supply_ok_i` has been sampled high on 4 consecutive clock edges. A glitch shorter than that restarts the count.
- R8: `fb_i`, `dt_i` and `push_pull_i` are sampled only at a ramp wrap (and at reset). A change part way through a cycle does not alter the pulse that is in progress.
- R9: A synchronous reset sets the ramp to 0, drives both outputs low, and points the steering at output 1.
- R10: With P=100 and both control values 0, each output is high for 96 of every 100 cycles in single-ended mode, and for 96 of every 200 cycles in push-pull mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok_i | input | 1 | Supply-good indication; low means lockout |
| push_pull_i | input | 1 | 1 = push-pull alternation, 0 = single-ended |
| period_i | input | CNT_W | Ramp period in clock cycles, sampled at wrap |
| fb_i | input | CNT_W | Feedback compare value |
| dt_i | input | CNT_W | Deadtime compare value |
| drv1_o | output | 1 | Drive output 1 |
| drv2_o | output | 1 | Drive output 2 |
| cyc_start_o | output | 1 | High while the ramp is at zero |

## Verification
The control pair is tried three ways: both zero, feedback dominant (50 over 20), and deadtime dominant (60 over 10). These show whether the larger value wins, and whether an on-time of 49 versus 39 cycles points to the right operand. The threshold is also moved to P−2 and P−1 to separate "strictly above" from "at or above", and it is changed mid-cycle to show that latching happens only at the wrap. Periods of 100, 37, 7 and 0 check the ceiling in the blanking width and the clamp to 2. Push-pull and single-ended windows, a fresh reset and short supply glitches cover alternation order and the lockout count.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

   // which lane the steering flip-flop currently points at
   typedef enum logic {
      STEER_A = 1'b0,
      STEER_B = 1'b1
   } steer_e;

   // blanking width: ceil(per * pct / 100) clock cycles
   function automatic int unsigned blank_cycles(input int unsigned per,
                                                input int unsigned pct);
      return (per * pct + 99) / 100;
   endfunction

endpackage

// File: rtl/pwm_dt_ramp.sv
module pwm_dt_ramp #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] per_i,
   output logic [CNT_W-1:0] ramp_o,
   output logic [CNT_W-1:0] per_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(2);

   logic [CNT_W-1:0] ramp_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] per_clamped;

   assign per_clamped = (per_i < PER_MIN) ? PER_MIN : per_i;
   assign wrap_o      = (ramp_q == per_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         ramp_q <= '0;
         per_q  <= per_clamped;
      end else if (wrap_o) begin
         ramp_q <= '0;
         per_q  <= per_clamped;
      end else begin
         ramp_q <= ramp_q + CNT_W'(1);
      end
   end

   assign ramp_o = ramp_q;
   assign per_o  = per_q;
endmodule

// File: rtl/pwm_dt_lockout.sv
module pwm_dt_lockout #(
   parameter int unsigned HOLD = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_ok_i,
   output logic ok_o
);
   localparam int unsigned HW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

   generate
      if (HOLD == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) ok_o <= 1'b0;
            else     ok_o <= raw_ok_i;
         end
      end else begin : g_filter
         logic [HW-1:0] run_q;
         always_ff @(posedge clk) begin
            if (rst || !raw_ok_i) begin
               run_q <= '0;
               ok_o  <= 1'b0;
            end else if (run_q != HW'(HOLD)) begin
               run_q <= run_q + HW'(1);
               ok_o  <= (run_q == HW'(HOLD - 1));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_dt_steer.sv
module pwm_dt_steer
   import pwm_dt_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wrap_i,
   input  logic       pp_next_i,
   input  logic       pp_i,
   input  logic       pulse_i,
   output logic [1:0] drv_o
);
   steer_e side_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         side_q <= STEER_A;
      end else if (wrap_i) begin
         if (pp_next_i) side_q <= (side_q == STEER_A) ? STEER_B : STEER_A;
         else           side_q <= STEER_A;
      end
   end

   generate
      for (genvar k = 0; k < 2; k++) begin : g_lane
         localparam steer_e LANE = (k == 0) ? STEER_A : STEER_B;
         assign drv_o[k] = pulse_i & (~pp_i | (side_q == LANE));
      end
   endgenerate
endmodule

// File: rtl/pwm_dt_ctrl.sv
module pwm_dt_ctrl #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned BLANK_PCT = 4,
   parameter int unsigned OK_HOLD   = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             supply_ok_i,
   input  logic             push_pull_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] fb_i,
   input  logic [CNT_W-1:0] dt_i,
   output logic             drv1_o,
   output logic             drv2_o,
   output logic             cyc_start_o
);
   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
      $error("pwm_dt_ctrl: CNT_W must lie in 2..24");
   end
   if (BLANK_PCT >= 100) begin : g_bad_pct
      $error("pwm_dt_ctrl: BLANK_PCT must be below 100");
   end

   logic [CNT_W-1:0] ramp_w;
   logic [CNT_W-1:0] per_w;
   logic             wrap_w;
   logic             ok_w;
   logic [CNT_W-1:0] fb_q;
   logic [CNT_W-1:0] dt_q;
   logic             pp_q;
   logic [CNT_W-1:0] thr_w;
   logic [CNT_W-1:0] blank_w;
   logic             pulse_w;
   logic [1:0]       drv_w;

   pwm_dt_ramp #(.CNT_W(CNT_W)) ramp_i (
      .clk    (clk),
      .rst    (rst),
      .per_i  (period_i),
      .ramp_o (ramp_w),
      .per_o  (per_w),
      .wrap_o (wrap_w)
   );

   pwm_dt_lockout #(.HOLD(OK_HOLD)) uvlo_i (
      .clk      (clk),
      .rst      (rst),
      .raw_ok_i (supply_ok_i),
      .ok_o     (ok_w)
   );

   // control values and mode change only at a wrap
   always_ff @(posedge clk) begin
      if (rst || wrap_w) begin
         fb_q <= fb_i;
         dt_q <= dt_i;
         pp_q <= push_pull_i;
      end
   end

   assign thr_w   = (fb_q > dt_q) ? fb_q : dt_q;
   assign blank_w = CNT_W'(pwm_dt_pkg::blank_cycles(32'(per_w), BLANK_PCT));
   assign pulse_w = ok_w && (ramp_w >= blank_w) && (ramp_w > thr_w);

   pwm_dt_steer steer_i (
      .clk       (clk),
      .rst       (rst),
      .wrap_i    (wrap_w),
      .pp_next_i (push_pull_i),
      .pp_i      (pp_q),
      .pulse_i   (pulse_w),
      .drv_o     (drv_w)
   );

   assign drv1_o      = drv_w[0];
   assign drv2_o      = drv_w[1];
   assign cyc_start_o = (ramp_w == '0);
endmodule

// File: rtl/pwm_dt_ctrl_chk.sv
module pwm_dt_ctrl_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] ramp,
   input logic [CNT_W-1:0] blank,
   input logic [CNT_W-1:0] fb_q,
   input logic [CNT_W-1:0] dt_q,
   input logic             pp_q,
   input logic             ok,
   input logic             drv1,
   input logic             drv2,
   input logic             start
);
   p_ramp_step_r1: assert property (@(posedge clk) disable iff (rst)
      (ramp != '0) |-> (ramp == $past(ramp) + CNT_W'(1)));

   p_start_zero_r1: assert property (@(posedge clk) disable iff (rst)
      start |-> (ramp == '0));

   p_above_thr_r2: assert property (@(posedge clk) disable iff (rst)
      (drv1 || drv2) |-> ((ramp > fb_q) && (ramp > dt_q)));

   p_blank_r3: assert property (@(posedge clk) disable iff (rst)
      (ramp < blank) |-> (!drv1 && !drv2));

   p_single_same_r5: assert property (@(posedge clk) disable iff (rst)
      !pp_q |-> (drv1 == drv2));

   p_pp_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
      pp_q |-> !(drv1 && drv2));

   p_lockout_r7: assert property (@(posedge clk) disable iff (rst)
      !ok |-> (!drv1 && !drv2));

   p_hold_ctrl_r8: assert property (@(posedge clk) disable iff (rst)
      (ramp != '0) |-> ($stable(fb_q) && $stable(dt_q) && $stable(pp_q)));
endmodule

bind pwm_dt_ctrl pwm_dt_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
   .clk   (clk),
   .rst   (rst),
   .ramp  (ramp_w),
   .blank (blank_w),
   .fb_q  (fb_q),
   .dt_q  (dt_q),
   .pp_q  (pp_q),
   .ok    (ok_w),
   .drv1  (drv1_o),
   .drv2  (drv2_o),
   .start (cyc_start_o)
);

// File: tb/pwm_dt_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_dt_ctrl_tb_top;
   localparam int W    = 8;
   localparam int HOLD = 4;
   localparam int PCT  = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         sup = 1'b0;
   logic         pp  = 1'b1;
   logic [W-1:0] per = 8'd100;
   logic [W-1:0] fb  = 8'd0;
   logic [W-1:0] dt  = 8'd0;
   logic         drv1, drv2, st;

   int    n_cmp  = 0;
   int    n_bad  = 0;
   bit    done   = 1'b0;
   string cur_req = "R9";

   always #2.5 clk = ~clk;

   pwm_dt_ctrl #(.CNT_W(W), .BLANK_PCT(PCT), .OK_HOLD(HOLD)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .supply_ok_i (sup),
      .push_pull_i (pp),
      .period_i    (per),
      .fb_i        (fb),
      .dt_i        (dt),
      .drv1_o      (drv1),
      .drv2_o      (drv2),
      .cyc_start_o (st)
   );

   // ---------------- behavioural reference model ----------------
   int m_ramp, m_per, m_fb, m_dt, m_pp, m_side, m_run, m_ok;

   function automatic int clampp(input int p);
      return (p < 2) ? 2 : p;
   endfunction

   always @(posedge clk) begin
      int thr, blk;
      bit pulse, e1, e2, es;
      if (rst) begin
         m_ramp = 0; m_per = clampp(int'(per));
         m_fb = int'(fb); m_dt = int'(dt); m_pp = int'(pp);
         m_side = 0; m_run = 0; m_ok = 0;
      end else begin
         if (sup) begin
            if (m_run < HOLD) m_run = m_run + 1;
         end else begin
            m_run = 0;
         end
         m_ok = (sup && m_run >= HOLD) ? 1 : 0;
         if (m_ramp == m_per - 1) begin
            m_ramp = 0;
            m_per  = clampp(int'(per));
            m_fb   = int'(fb);
            m_dt   = int'(dt);
            m_side = pp ? (1 - m_side) : 0;
            m_pp   = int'(pp);
         end else begin
            m_ramp = m_ramp + 1;
         end
      end
      thr   = (m_fb > m_dt) ? m_fb : m_dt;
      blk   = (m_per * PCT + 99) / 100;
      pulse = (m_ok == 1) && (m_ramp >= blk) && (m_ramp > thr);
      e1    = pulse && (m_pp == 0 || m_side == 0);
      e2    = pulse && (m_pp == 0 || m_side == 1);
      es    = (m_ramp == 0);
      #1;
      if (!done) begin
         n_cmp++;
         if (drv1 !== e1 || drv2 !== e2 || st !== es) begin
            n_bad++;
            $display("FAIL %s clock compare: drv1/drv2/start=%b%b%b expected %b%b%b",
                     cur_req, drv1, drv2, st, e1, e2, es);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wait_start();
      do tick(); while (!st);
   endtask

   // counts samples starting with the current one
   task automatic count_win(input int n, output int c1, output int c2,
                            output int cb, output int cs);
      c1 = 0; c2 = 0; cb = 0; cs = 0;
      for (int i = 0; i < n; i++) begin
         if (i > 0) tick();
         c1 += int'(drv1); c2 += int'(drv2);
         cb += int'(drv1 && drv2); cs += int'(st);
      end
   endtask

   task automatic set_ctrl(input int f, input int d, input bit m, input int p);
      @(negedge clk);
      fb = W'(f); dt = W'(d); pp = m; per = W'(p);
   endtask

   task automatic finish_up();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         finish_up();
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int c1, c2, cb, cs, a1, a2;
      repeat (3) tick();
      // R9: reset state
      chk(drv1 == 1'b0 && drv2 == 1'b0, "R9 outputs low in reset", int'({drv1, drv2}), 0);
      chk(st == 1'b1, "R9 ramp at zero in reset", int'(st), 1);
      @(negedge clk); rst = 1'b0;

      // R7: held in lockout while supply is low
      cur_req = "R7";
      count_win(150, c1, c2, cb, cs);
      chk(c1 + c2 == 0, "R7 no drive during lockout", c1 + c2, 0);
      @(negedge clk); sup = 1'b1;

      // R10 / R6: push-pull duty at P=100
      cur_req = "R10";
      wait_start();
      count_win(200, c1, c2, cb, cs);
      chk(c1 == 96, "R10 push-pull drv1 on-time per 200", c1, 96);
      chk(c2 == 96, "R10 push-pull drv2 on-time per 200", c2, 96);
      chk(cb == 0, "R6 overlap in push-pull", cb, 0);

      // R4: alternation across consecutive cycles
      cur_req = "R4";
      wait_start();
      count_win(100, c1, c2, cb, cs);
      a1 = c1; a2 = c2;
      tick();
      count_win(100, c1, c2, cb, cs);
      chk((a1 == 96 && a2 == 0 && c1 == 0 && c2 == 96) ||
          (a1 == 0 && a2 == 96 && c1 == 96 && c2 == 0),
          "R4 alternation drv1 first-window", a1, c2);

      // R4 / R9: output 1 leads after a fresh reset
      @(negedge clk); rst = 1'b1;
      cur_req = "R9";
      tick(); tick();
      @(negedge clk); rst = 1'b0;
      cur_req = "R4";
      tick();
      count_win(99, c1, c2, cb, cs);
      chk(c1 == 96, "R4 drv1 leads after reset", c1, 96);
      chk(c2 == 0, "R4 drv2 idle in first cycle", c2, 0);

      // R5 / R10: single-ended
      cur_req = "R5";
      set_ctrl(0, 0, 1'b0, 100);
      wait_start();
      count_win(100, c1, c2, cb, cs);
      chk(c1 == 96, "R10 single-ended drv1 on-time", c1, 96);
      chk(c2 == 96, "R5 single-ended drv2 on-time", c2, 96);

      // R2: larger control value wins
      cur_req = "R2";
      set_ctrl(50, 20, 1'b0, 100);
      wait_start();
      count_win(100, c1, c2, cb, cs);
      chk(c1 == 49, "R2 feedback dominant", c1, 49);
      set_ctrl(10, 60, 1'b0, 100);
      wait_start();
      count_win(100, c1, c2, cb, cs);
      chk(c1 == 39, "R2 deadtime dominant", c1, 39);
      set_ctrl(98, 0, 1'b0, 100);
      wait_start();
      count_win(100, c1, c2, cb, cs);
      chk(c1 == 1, "R2 threshold P-2", c1, 1);
      set_ctrl(99, 0, 1'b0, 100);
      wait_start();
      count_win(100, c1, c2, cb, cs);
      chk(c1 == 0, "R2 threshold P-1 gives zero", c1, 0);

      // R8: mid-cycle change does not disturb current pulse
      cur_req = "R8";
      set_ctrl(50, 0, 1'b0, 100);
      wait_start();
      c1 = 0;
      for (int i = 0; i < 100; i++) begin
         if (i > 0) tick();
         c1 += int'(drv1);
         if (i == 20) begin @(negedge clk); fb = 8'd90; pp = 1'b1; end
      end
      chk(c1 == 49, "R8 pulse kept mid-cycle", c1, 49);
      tick();
      count_win(100, c1, c2, cb, cs);
      chk(c1 + c2 == 9, "R8 new value from next cycle", c1 + c2, 9);

      // R1 / R3: other periods
      cur_req = "R3";
      set_ctrl(0, 0, 1'b0, 37);
      wait_start();
      count_win(74, c1, c2, cb, cs);
      chk(c1 == 70, "R3 blank of 2 at P=37", c1, 70);
      chk(cs == 2, "R1 wraps at P=37", cs, 2);
      set_ctrl(0, 0, 1'b0, 7);
      wait_start();
      count_win(7, c1, c2, cb, cs);
      chk(c1 == 6, "R3 blank of 1 at P=7", c1, 6);
      cur_req = "R1";
      set_ctrl(0, 0, 1'b1, 0);
      wait_start();
      count_win(8, c1, c2, cb, cs);
      chk(cs == 4, "R1 period 0 clamped to 2", cs, 4);
      chk(c1 == 2 && c2 == 2, "R1 clamp drive per lane", c1 + c2, 4);

      // R7: glitch restarts the qualify count
      cur_req = "R7";
      set_ctrl(0, 0, 1'b0, 100);
      wait_start();
      repeat (10) tick();
      @(negedge clk); sup = 1'b0;
      @(negedge clk); @(negedge clk); sup = 1'b1;
      @(negedge clk); @(negedge clk); sup = 1'b0;
      tick();
      count_win(5, c1, c2, cb, cs);
      chk(c1 + c2 == 0, "R7 glitch keeps outputs low", c1 + c2, 0);
      @(negedge clk); sup = 1'b1;
      repeat (3) tick();
      chk(drv1 == 1'b0, "R7 still locked after 3 good edges", int'(drv1), 0);
      tick();
      chk(drv1 == 1'b1, "R7 released after 4 good edges", int'(drv1), 1);
      repeat (20) tick();

      done = 1'b1;
      finish_up();
   end
endmodule